// File: doc/BRIEF.md
# Debug Trigger Register File

This block holds the software-visible state of a small bank of address-match debug triggers. Software picks one trigger through a selector register. It then reads or writes that trigger's packed control word and its compare value through two data registers that share a single window. A third data register exists only so that accesses to it are well defined: it always reads as zero.

Every trigger presents its decoded control fields and its compare value on dedicated output buses. The external match logic compares addresses against them. Three summary flags tell that logic whether any trigger watches instruction fetches, loads or stores, so it can skip unused comparators.

A trigger can be claimed by debug mode through its dmode bit. While the hart runs outside debug mode, that trigger's control word and compare value cannot be changed. When software asks for execute matching, the timing bit is cleared in the stored control word.

Top module: `dtrig_regfile`

## Requirements
- R1: After reset the selector reads 0. Every control word reads 2 in its top four bits, the MASK_MAX constant in the six bits below the dmode bit, and 0 in all other bits. Every compare value is 0 and all three summary flags are 0.
- R2: A write to the selector (ADDR_SEL) is stored only when the written value, taken as an unsigned number, is below NUM_TRIG. Any other value leaves the selector unchanged. The selector reads back zero-extended.
- R3: A control write (ADDR_CTRL) stores the writable fields: dmode at bit XLEN-5, select at 19, timing at 18, action at 17:12, chain at 11, match at 10:7, M at 6, S at 4, U at 3, execute at 2, store at 1 and load at 0. Bits 5 and 20 to XLEN-12 read 0. The type and maskmax fields cannot be written.
- R4: When a control write has the execute bit (bit 2) set, the stored timing bit (bit 18) is 0 whatever value was written to it. With execute clear, the timing bit is stored as written.
- R5: A compare write (ADDR_CMP) stores the full XLEN-bit value for the selected trigger, and that value reads back unchanged.
- R6: While the selected trigger has dmode set and in_debug is low, writes to its control word and to its compare value are ignored. With in_debug high, both writes are accepted.
- R7: ADDR_AUX and any unmapped address read 0. Writes to them change no state.
- R8: Control and compare writes change only the selected trigger. The output buses trig_ctrl_o and trig_cmp_o carry trigger k in slice k.
- R9: any_fetch_o, any_load_o and any_store_o are the OR, over all triggers, of the stored execute, load and store bits respectively.
- R10: csr_rdata is a combinational function of csr_addr and the stored state. A write becomes visible on the cycle after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | ADDR_W | Register address |
| csr_wdata | input | XLEN | Write data |
| csr_we | input | 1 | Write enable |
| csr_rdata | output | XLEN | Read data for csr_addr |
| in_debug | input | 1 | Hart is in debug mode |
| trig_ctrl_o | output | NUM_TRIG*XLEN | Packed control word of every trigger |
| trig_cmp_o | output | NUM_TRIG*XLEN | Compare value of every trigger |
| any_fetch_o | output | 1 | Some trigger has execute matching enabled |
| any_load_o | output | 1 | Some trigger has load matching enabled |
| any_store_o | output | 1 | Some trigger has store matching enabled |

## Verification
On every cycle the assertions check the following invariants. The selector stays in range and holds across an out-of-range write. Each trigger's type field stays 2. No stored control word has both execute and timing set. A locked trigger keeps its control word across a write made outside debug mode. The auxiliary register reads zero. An accepted compare write lands in the slice of the trigger that was selected.

The bench's scenarios are needed to show the rest. They show the exact field mask of a control write, and that writes leave the other triggers untouched. They show that the lock lifts in debug mode, and that the lock is per trigger rather than global. They also show the arithmetic link between the stored bits and the three summary flags.

// File: rtl/dtrig_pkg.sv
package dtrig_pkg;

    // Low-order field positions of the control word (decoded by the match logic)
    localparam int unsigned LOW_W      = 20;
    localparam int unsigned B_LOAD     = 0;
    localparam int unsigned B_STORE    = 1;
    localparam int unsigned B_EXEC     = 2;
    localparam int unsigned B_U        = 3;
    localparam int unsigned B_S        = 4;
    localparam int unsigned B_M        = 6;
    localparam int unsigned B_MATCH    = 7;
    localparam int unsigned B_CHAIN    = 11;
    localparam int unsigned B_ACTION   = 12;
    localparam int unsigned B_TIMING   = 18;
    localparam int unsigned B_SELECT   = 19;

    localparam logic [3:0] TRIG_KIND   = 4'd2;

    typedef struct packed {
        logic       dmode;
        logic       addr_sel;
        logic       timing;
        logic [5:0] action;
        logic       chain;
        logic [3:0] match;
        logic       en_m;
        logic       en_s;
        logic       en_u;
        logic       on_exec;
        logic       on_store;
        logic       on_load;
    } trig_cfg_t;

    function automatic trig_cfg_t decode_low(input logic [LOW_W-1:0] w, input logic dm);
        trig_cfg_t c;
        c.dmode    = dm;
        c.addr_sel = w[B_SELECT];
        c.timing   = w[B_TIMING];
        c.action   = w[B_ACTION +: 6];
        c.chain    = w[B_CHAIN];
        c.match    = w[B_MATCH +: 4];
        c.en_m     = w[B_M];
        c.en_s     = w[B_S];
        c.en_u     = w[B_U];
        c.on_exec  = w[B_EXEC];
        c.on_store = w[B_STORE];
        c.on_load  = w[B_LOAD];
        return c;
    endfunction

    function automatic logic [LOW_W-1:0] encode_low(input trig_cfg_t c);
        logic [LOW_W-1:0] w;
        w              = '0;
        w[B_SELECT]    = c.addr_sel;
        w[B_TIMING]    = c.timing;
        w[B_ACTION+:6] = c.action;
        w[B_CHAIN]     = c.chain;
        w[B_MATCH+:4]  = c.match;
        w[B_M]         = c.en_m;
        w[B_S]         = c.en_s;
        w[B_U]         = c.en_u;
        w[B_EXEC]      = c.on_exec;
        w[B_STORE]     = c.on_store;
        w[B_LOAD]      = c.on_load;
        return w;
    endfunction

endpackage

// File: rtl/dtrig_select.sv
module dtrig_select #(
    parameter int unsigned XLEN     = 32,
    parameter int unsigned NUM_TRIG = 4,
    localparam int unsigned SEL_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [XLEN-1:0]  wdata,
    output logic [SEL_W-1:0] sel_o
);
    logic [SEL_W-1:0] sel_d, sel_q;
    logic             in_range;

    always_comb begin
        in_range = (wdata < XLEN'(NUM_TRIG));
        sel_d    = sel_q;
        if (wr && in_range) begin
            sel_d = wdata[SEL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    assign sel_o = sel_q;
endmodule

// File: rtl/dtrig_slot.sv
module dtrig_slot
    import dtrig_pkg::*;
#(
    parameter int unsigned XLEN     = 32,
    parameter logic [5:0]  MASK_MAX = 6'd5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_debug,
    input  logic            wr_ctrl,
    input  logic            wr_cmp,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] ctrl_word,
    output logic [XLEN-1:0] cmp_word,
    output trig_cfg_t       cfg_o
);
    localparam int unsigned DMODE_BIT = XLEN - 5;

    typedef struct packed {
        trig_cfg_t       cfg;
        logic [XLEN-1:0] cmp;
    } slot_state_t;

    slot_state_t st_d, st_q;
    logic        locked;

    always_comb begin
        st_d   = st_q;
        locked = st_q.cfg.dmode && !in_debug;
        if (wr_ctrl && !locked) begin
            st_d.cfg = decode_low(wdata[LOW_W-1:0], wdata[DMODE_BIT]);
            if (st_d.cfg.on_exec) begin
                st_d.cfg.timing = 1'b0;
            end
        end
        if (wr_cmp && !locked) begin
            st_d.cmp = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        ctrl_word                  = '0;
        ctrl_word[XLEN-1 -: 4]     = TRIG_KIND;
        ctrl_word[DMODE_BIT]       = st_q.cfg.dmode;
        ctrl_word[XLEN-6 -: 6]     = MASK_MAX;
        ctrl_word[LOW_W-1:0]       = encode_low(st_q.cfg);
    end

    assign cmp_word = st_q.cmp;
    assign cfg_o    = st_q.cfg;
endmodule

// File: rtl/dtrig_rdmux.sv
module dtrig_rdmux #(
    parameter int unsigned XLEN      = 32,
    parameter int unsigned NUM_TRIG  = 4,
    parameter int unsigned ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] ADDR_SEL  = 12'h7A0,
    parameter logic [ADDR_W-1:0] ADDR_CTRL = 12'h7A1,
    parameter logic [ADDR_W-1:0] ADDR_CMP  = 12'h7A2,
    localparam int unsigned SEL_W    = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
    input  logic [ADDR_W-1:0]        addr,
    input  logic [SEL_W-1:0]         sel,
    input  logic [NUM_TRIG*XLEN-1:0] ctrl_bus,
    input  logic [NUM_TRIG*XLEN-1:0] cmp_bus,
    output logic [XLEN-1:0]          rdata
);
    logic [XLEN-1:0] ctrl_pick, cmp_pick;

    always_comb begin
        ctrl_pick = '0;
        cmp_pick  = '0;
        for (int k = 0; k < NUM_TRIG; k++) begin
            if (sel == SEL_W'(k)) begin
                ctrl_pick = ctrl_bus[k*XLEN +: XLEN];
                cmp_pick  = cmp_bus[k*XLEN +: XLEN];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_SEL)       rdata = XLEN'(sel);
        else if (addr == ADDR_CTRL) rdata = ctrl_pick;
        else if (addr == ADDR_CMP)  rdata = cmp_pick;
    end
endmodule

// File: rtl/dtrig_regfile.sv
module dtrig_regfile
    import dtrig_pkg::*;
#(
    parameter int unsigned XLEN      = 32,
    parameter int unsigned NUM_TRIG  = 4,
    parameter int unsigned ADDR_W    = 12,
    parameter logic [5:0]  MASK_MAX  = 6'd5,
    parameter logic [ADDR_W-1:0] ADDR_SEL  = 12'h7A0,
    parameter logic [ADDR_W-1:0] ADDR_CTRL = 12'h7A1,
    parameter logic [ADDR_W-1:0] ADDR_CMP  = 12'h7A2,
    parameter logic [ADDR_W-1:0] ADDR_AUX  = 12'h7A3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        csr_addr,
    input  logic [XLEN-1:0]          csr_wdata,
    input  logic                     csr_we,
    output logic [XLEN-1:0]          csr_rdata,
    input  logic                     in_debug,
    output logic [NUM_TRIG*XLEN-1:0] trig_ctrl_o,
    output logic [NUM_TRIG*XLEN-1:0] trig_cmp_o,
    output logic                     any_fetch_o,
    output logic                     any_load_o,
    output logic                     any_store_o
);
    localparam int unsigned SEL_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;

    logic [SEL_W-1:0]    sel_q;
    logic                wr_sel, wr_ctrl_any, wr_cmp_any;
    logic [NUM_TRIG-1:0] wr_ctrl, wr_cmp;
    trig_cfg_t           cfg [NUM_TRIG];

    always_comb begin
        wr_sel      = csr_we && (csr_addr == ADDR_SEL);
        wr_ctrl_any = csr_we && (csr_addr == ADDR_CTRL);
        wr_cmp_any  = csr_we && (csr_addr == ADDR_CMP);
        for (int k = 0; k < NUM_TRIG; k++) begin
            wr_ctrl[k] = wr_ctrl_any && (sel_q == SEL_W'(k));
            wr_cmp[k]  = wr_cmp_any  && (sel_q == SEL_W'(k));
        end
    end

    dtrig_select #(.XLEN(XLEN), .NUM_TRIG(NUM_TRIG)) u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_sel),
        .wdata (csr_wdata),
        .sel_o (sel_q)
    );

    for (genvar g = 0; g < NUM_TRIG; g++) begin : g_slot
        dtrig_slot #(.XLEN(XLEN), .MASK_MAX(MASK_MAX)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_debug  (in_debug),
            .wr_ctrl   (wr_ctrl[g]),
            .wr_cmp    (wr_cmp[g]),
            .wdata     (csr_wdata),
            .ctrl_word (trig_ctrl_o[g*XLEN +: XLEN]),
            .cmp_word  (trig_cmp_o[g*XLEN +: XLEN]),
            .cfg_o     (cfg[g])
        );
    end

    dtrig_rdmux #(
        .XLEN(XLEN), .NUM_TRIG(NUM_TRIG), .ADDR_W(ADDR_W),
        .ADDR_SEL(ADDR_SEL), .ADDR_CTRL(ADDR_CTRL), .ADDR_CMP(ADDR_CMP)
    ) u_rd (
        .addr     (csr_addr),
        .sel      (sel_q),
        .ctrl_bus (trig_ctrl_o),
        .cmp_bus  (trig_cmp_o),
        .rdata    (csr_rdata)
    );

    always_comb begin
        any_fetch_o = 1'b0;
        any_load_o  = 1'b0;
        any_store_o = 1'b0;
        for (int k = 0; k < NUM_TRIG; k++) begin
            any_fetch_o = any_fetch_o | cfg[k].on_exec;
            any_load_o  = any_load_o  | cfg[k].on_load;
            any_store_o = any_store_o | cfg[k].on_store;
        end
    end
endmodule

// File: rtl/dtrig_regfile_chk.sv
module dtrig_regfile_chk #(
    parameter int unsigned XLEN      = 32,
    parameter int unsigned NUM_TRIG  = 4,
    parameter int unsigned ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] ADDR_SEL  = 12'h7A0,
    parameter logic [ADDR_W-1:0] ADDR_CTRL = 12'h7A1,
    parameter logic [ADDR_W-1:0] ADDR_CMP  = 12'h7A2,
    parameter logic [ADDR_W-1:0] ADDR_AUX  = 12'h7A3,
    localparam int unsigned SEL_W    = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [ADDR_W-1:0]        csr_addr,
    input logic [XLEN-1:0]          csr_wdata,
    input logic                     csr_we,
    input logic [XLEN-1:0]          csr_rdata,
    input logic                     in_debug,
    input logic [NUM_TRIG*XLEN-1:0] trig_ctrl_o,
    input logic [NUM_TRIG*XLEN-1:0] trig_cmp_o,
    input logic [SEL_W-1:0]         sel_q
);
    logic [XLEN-1:0] ctrl_arr [NUM_TRIG];
    logic [XLEN-1:0] cmp_arr  [NUM_TRIG];
    logic [XLEN-1:0] sel_ctrl, sel_cmp;

    always_comb begin
        sel_ctrl = '0;
        sel_cmp  = '0;
        for (int k = 0; k < NUM_TRIG; k++) begin
            ctrl_arr[k] = trig_ctrl_o[k*XLEN +: XLEN];
            cmp_arr[k]  = trig_cmp_o[k*XLEN +: XLEN];
            if (sel_q == SEL_W'(k)) begin
                sel_ctrl = ctrl_arr[k];
                sel_cmp  = cmp_arr[k];
            end
        end
    end

    p_sel_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(sel_q) < NUM_TRIG);

    p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_addr == ADDR_SEL && csr_wdata >= XLEN'(NUM_TRIG)) |=> $stable(sel_q));

    p_lock_ctrl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_addr == ADDR_CTRL && !in_debug && sel_ctrl[XLEN-5]) |=> $stable(trig_ctrl_o));

    p_cmp_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_addr == ADDR_CMP && !(sel_ctrl[XLEN-5] && !in_debug)) |=> (sel_cmp == $past(csr_wdata)));

    p_aux_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == ADDR_AUX) |-> (csr_rdata == '0));

    for (genvar g = 0; g < NUM_TRIG; g++) begin : g_chk
        p_kind_r1: assert property (@(posedge clk) disable iff (!rst_n)
            trig_ctrl_o[g*XLEN + XLEN - 4 +: 4] == 4'd2);
        p_exec_timing_r4: assert property (@(posedge clk) disable iff (!rst_n)
            trig_ctrl_o[g*XLEN + 2] |-> !trig_ctrl_o[g*XLEN + 18]);
    end
endmodule

bind dtrig_regfile dtrig_regfile_chk #(
    .XLEN(XLEN), .NUM_TRIG(NUM_TRIG), .ADDR_W(ADDR_W),
    .ADDR_SEL(ADDR_SEL), .ADDR_CTRL(ADDR_CTRL), .ADDR_CMP(ADDR_CMP), .ADDR_AUX(ADDR_AUX)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_addr    (csr_addr),
    .csr_wdata   (csr_wdata),
    .csr_we      (csr_we),
    .csr_rdata   (csr_rdata),
    .in_debug    (in_debug),
    .trig_ctrl_o (trig_ctrl_o),
    .trig_cmp_o  (trig_cmp_o),
    .sel_q       (sel_q)
);

// File: tb/dtrig_regfile_tb.sv
`timescale 1ns/1ps
module dtrig_regfile_tb;
    localparam int unsigned XLEN = 32;
    localparam int unsigned NT   = 4;
    localparam logic [11:0] A_SEL  = 12'h7A0;
    localparam logic [11:0] A_CTRL = 12'h7A1;
    localparam logic [11:0] A_CMP  = 12'h7A2;
    localparam logic [11:0] A_AUX  = 12'h7A3;
    localparam logic [31:0] CONSTS = (32'd2 << 28) | (32'd5 << 21);
    localparam logic [31:0] WMASK  = (32'd1 << 27) | 32'h000F_FFDF;

    logic              clk = 0, rst_n = 0, csr_we = 0, in_debug = 0;
    logic [11:0]       csr_addr = '0;
    logic [31:0]       csr_wdata = '0, csr_rdata;
    logic [NT*32-1:0]  trig_ctrl_o, trig_cmp_o;
    logic              any_fetch_o, any_load_o, any_store_o;

    int checks = 0, failures = 0;
    logic [31:0] m_ctrl [NT];
    logic [31:0] m_cmp  [NT];
    int          m_sel;

    always #2.5 clk = ~clk;

    dtrig_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_we(csr_we), .csr_rdata(csr_rdata), .in_debug(in_debug),
        .trig_ctrl_o(trig_ctrl_o), .trig_cmp_o(trig_cmp_o),
        .any_fetch_o(any_fetch_o), .any_load_o(any_load_o), .any_store_o(any_store_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_addr = a; csr_wdata = d; csr_we = 1;
        @(negedge clk);
        csr_we = 0;
        // model update
        if (a == A_SEL && d < NT) m_sel = int'(d);
        if (!(m_ctrl[m_sel][27] && !in_debug)) begin
            if (a == A_CTRL) begin
                m_ctrl[m_sel] = (d & WMASK) | CONSTS;
                if (d[2]) m_ctrl[m_sel][18] = 1'b0;
            end
            if (a == A_CMP) m_cmp[m_sel] = d;
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        csr_addr = a;
        #1;
        v = csr_rdata;
    endtask

    task automatic chk_all(input string req);
        logic f, l, s;
        f = 0; l = 0; s = 0;
        for (int k = 0; k < NT; k++) begin
            chk({req, " R8 ctrl slice"}, trig_ctrl_o[k*32 +: 32], m_ctrl[k]);
            chk({req, " R8 cmp slice"},  trig_cmp_o[k*32 +: 32],  m_cmp[k]);
            f |= m_ctrl[k][2]; l |= m_ctrl[k][0]; s |= m_ctrl[k][1];
        end
        chk("R9 fetch flag", 32'(any_fetch_o), 32'(f));
        chk("R9 load flag",  32'(any_load_o),  32'(l));
        chk("R9 store flag", 32'(any_store_o), 32'(s));
    endtask

    initial begin
        #100000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v, p;
        for (int k = 0; k < NT; k++) begin m_ctrl[k] = CONSTS; m_cmp[k] = 0; end
        m_sel = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rd(A_SEL, v);  chk("R1 sel", v, 0);
        rd(A_CTRL, v); chk("R1 ctrl read", v, CONSTS);
        rd(A_CMP, v);  chk("R1 cmp read", v, 0);
        chk_all("R1");

        // R2 select sweep
        for (int i = 0; i < 12; i++) begin
            p = (i < 10) ? 32'(i) : ((i == 10) ? 32'hFFFF_FFFF : 32'h8000_0001);
            wr(A_SEL, p);
            rd(A_SEL, v); chk("R2 select", v, 32'(m_sel));
        end

        // R3 R4 R8 control sweep, R5 compare sweep, R10 read after write
        for (int t = 0; t < NT; t++) begin
            wr(A_SEL, 32'(t));
            for (int k = 0; k < 6; k++) begin
                p = (32'h9E37_79B9 * 32'(t * 6 + k + 1)) & ~(32'd1 << 27);
                if (k == 0) p = p | 32'h0004_0004;          // exec with timing
                if (k == 1) p = (p | 32'h0004_0000) & ~32'h4; // timing without exec
                wr(A_CTRL, p);
                rd(A_CTRL, v); chk("R3 R4 R10 ctrl readback", v, m_ctrl[t]);
                if (k == 0) chk("R4 timing cleared", 32'(v[18]), 0);
                if (k == 1) chk("R4 timing kept", 32'(v[18]), 1);
                chk_all("R3");
            end
            wr(A_CMP, 32'hC0DE_0000 ^ (32'h0101_0101 * 32'(t + 3)));
            rd(A_CMP, v); chk("R5 cmp readback", v, m_cmp[t]);
            chk_all("R5");
        end

        // R7 aux and unmapped addresses
        wr(A_AUX, 32'hFFFF_FFFF);
        rd(A_AUX, v); chk("R7 aux read", v, 0);
        wr(12'h123, 32'hFFFF_FFFF);
        rd(12'h123, v); chk("R7 unmapped read", v, 0);
        rd(A_SEL, v); chk("R7 sel unchanged", v, 32'(m_sel));
        chk_all("R7");

        // R6 lock by dmode
        wr(A_SEL, 1);
        in_debug = 1;
        wr(A_CTRL, (32'd1 << 27) | 32'h0000_0003);
        rd(A_CTRL, v); chk("R6 dmode set in debug", v, CONSTS | (32'd1 << 27) | 3);
        in_debug = 0;
        wr(A_CTRL, 32'h0000_0004);
        rd(A_CTRL, v); chk("R6 ctrl locked", v, CONSTS | (32'd1 << 27) | 3);
        p = m_cmp[1];
        wr(A_CMP, 32'h1234_5678);
        rd(A_CMP, v); chk("R6 cmp locked", v, p);
        chk_all("R6");
        wr(A_SEL, 2);
        wr(A_CTRL, 32'h0000_0044);
        rd(A_CTRL, v); chk("R6 other trigger free", v, CONSTS | 32'h44);
        wr(A_SEL, 1);
        in_debug = 1;
        wr(A_CMP, 32'hA5A5_5A5A);
        rd(A_CMP, v); chk("R6 cmp in debug", v, 32'hA5A5_5A5A);
        wr(A_CTRL, 32'h0000_0000);
        rd(A_CTRL, v); chk("R6 ctrl in debug", v, CONSTS);
        in_debug = 0;
        chk_all("R6 R9");

        // R9 clear all triggers
        for (int t = 0; t < NT; t++) begin
            wr(A_SEL, 32'(t));
            wr(A_CTRL, 0);
        end
        chk_all("R9 cleared");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule